// File: doc/BRIEF.md
# Serial Gain Word Receiver

This block is the device-side receiver for a three-wire gain programming port. A host pulls an active-low enable line low, then clocks a gain word in on a serial data line, most significant bit first, one bit on each rising edge of a serial clock. When the host releases the enable, the received word is copied into a parallel gain latch that steers an attenuator core.

All three serial pins are oversampled by a single system clock through two-flop synchronizers, and their edges are found in that clock domain. Only seven bits are kept, so in a normal eight-bit word the leading bit falls off the end of the register. The latched code is split into a fine vernier step (low three bits) and a coarse attenuation step (high four bits, each worth eight vernier steps). A validity flag marks codes in the monotonic range, and a length flag reports a load whose bit count was not eight.

Top module: `gain_word_rx`

## Requirements
- R1: After reset the gain latch holds code 0, the shift register is cleared, code_valid_o is 1 and bit_cnt_err_o is 0.
- R2: While the enable is low, the latched gain code keeps its previous value regardless of serial activity.
- R3: With the enable low, each rising edge of the serial clock shifts the data line into bit 0 of the register, so bits arrive most significant first.
- R4: The register is 7 bits wide; of an 8-bit word the first bit is discarded and the latched code equals the last seven bits.
- R5: The latch updates only on a rising edge of the enable; serial clock edges while the enable is high leave the register unchanged.
- R6: fine_step_o equals code bits [2:0] and coarse_step_o equals code bits [6:3].
- R7: code_valid_o is 1 exactly when the 7-bit latched code is 71 or less; an 8-bit word with the top bit set is judged on its low seven bits only.
- R8: When the enable rises after a bit count other than 8, the register contents are latched anyway and bit_cnt_err_o is set; an 8-bit load clears it. The flag changes only when the latch is written.
- R9: The register is not cleared by a falling enable edge: bits left from earlier activity remain and shift onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock used to oversample the serial pins |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sen_ni | input | 1 | Active-low load enable from the host |
| sdat_i | input | 1 | Serial gain data |
| sclk_i | input | 1 | Serial clock, data taken on its rising edge |
| gain_code_o | output | 7 | Latched gain code |
| coarse_step_o | output | 4 | Coarse attenuation step |
| fine_step_o | output | 3 | Vernier step |
| code_valid_o | output | 1 | Latched code within 0..71 |
| bit_cnt_err_o | output | 1 | Last load did not contain exactly 8 bits |

## Verification
Full 8-bit words from a fixed-seed random source separate correct MSB-first shifting and the discarded leading bit from bit-order or width mistakes. Directed codes 71, 72, 127 and 199 sit on the validity boundary and show that the eighth bit has no effect on the flag or the split. Short and long words, and stray serial clocks sent while the enable is high followed by an empty load, reveal the bit-count flag, the retained register contents and any shifting outside the load window. A mid-word check confirms the latch holds during a load.

// File: rtl/gwr_pkg.sv
package gwr_pkg;
  localparam int unsigned WORD_BITS = 8;
  localparam int unsigned CODE_BITS = 7;
  localparam int unsigned FINE_BITS = 3;
  localparam int unsigned COARSE_BITS = CODE_BITS - FINE_BITS;
  localparam int unsigned MAX_VALID = 71;
  localparam int unsigned CNT_BITS = $clog2(WORD_BITS) + 1;
endpackage

// File: rtl/gwr_sync.sv
module gwr_sync #(
  parameter int unsigned N = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] pin_i,
  input  logic [N-1:0] rst_val_i,
  output logic [N-1:0] lvl_o,
  output logic [N-1:0] rise_o,
  output logic [N-1:0] fall_o
);
  for (genvar i = 0; i < N; i++) begin : g_pin
    logic s1_q, s2_q, d_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s1_q <= rst_val_i[i];
        s2_q <= rst_val_i[i];
        d_q  <= rst_val_i[i];
      end else begin
        s1_q <= pin_i[i];
        s2_q <= s1_q;
        d_q  <= s2_q;
      end
    end
    assign lvl_o[i]  = s2_q;
    assign rise_o[i] = s2_q & ~d_q;
    assign fall_o[i] = ~s2_q & d_q;
  end
endmodule

// File: rtl/gwr_shifter.sv
module gwr_shifter
  import gwr_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 en_lvl_i,
  input  logic                 en_rise_i,
  input  logic                 en_fall_i,
  input  logic                 sclk_rise_i,
  input  logic                 sdat_i,
  output logic [CODE_BITS-1:0] code_o,
  output logic                 cnt_err_o
);
  localparam logic [CNT_BITS-1:0] CNT_MAX  = '1;
  localparam logic [CNT_BITS-1:0] CNT_WORD = CNT_BITS'(WORD_BITS);

  logic [CODE_BITS-1:0] sreg_q, gain_q;
  logic [CNT_BITS-1:0]  cnt_q;
  logic                 err_q;
  logic                 shift_en;

  assign shift_en = ~en_lvl_i & sclk_rise_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sreg_q <= '0;
      cnt_q  <= '0;
    end else if (en_fall_i) begin
      cnt_q  <= '0;
    end else if (shift_en) begin
      sreg_q <= {sreg_q[CODE_BITS-2:0], sdat_i};
      if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gain_q <= '0;
      err_q  <= 1'b0;
    end else if (en_rise_i) begin
      gain_q <= sreg_q;
      err_q  <= (cnt_q != CNT_WORD);
    end
  end

  assign code_o    = gain_q;
  assign cnt_err_o = err_q;

  p_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_rise_i |=> $stable(gain_q));
  p_no_shift_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_lvl_i |=> $stable(sreg_q));
  p_cnt_clear_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_fall_i |=> (cnt_q == '0));
  p_err_stable_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_rise_i |=> $stable(err_q));
endmodule

// File: rtl/gwr_decode.sv
module gwr_decode
  import gwr_pkg::*;
(
  input  logic [CODE_BITS-1:0]   code_i,
  output logic [COARSE_BITS-1:0] coarse_o,
  output logic [FINE_BITS-1:0]   fine_o,
  output logic                   valid_o
);
  assign fine_o   = code_i[FINE_BITS-1:0];
  assign coarse_o = code_i[CODE_BITS-1:FINE_BITS];
  assign valid_o  = (32'(code_i) <= MAX_VALID);

  // each coarse step spans eight vernier steps; the valid range ends inside coarse step 8
  always_comb begin
    a_valid_coarse_r7: assert (!valid_o || (32'(coarse_o) <= MAX_VALID / 8));
  end
endmodule

// File: rtl/gain_word_rx.sv
module gain_word_rx
  import gwr_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sen_ni,
  input  logic       sdat_i,
  input  logic       sclk_i,
  output logic [6:0] gain_code_o,
  output logic [3:0] coarse_step_o,
  output logic [2:0] fine_step_o,
  output logic       code_valid_o,
  output logic       bit_cnt_err_o
);
  localparam int unsigned P_EN = 0, P_DAT = 1, P_CLK = 2;

  logic [2:0] lvl, rise, fall;
  logic [CODE_BITS-1:0] code;

  gwr_sync #(.N(3)) u_sync (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .pin_i    ({sclk_i, sdat_i, sen_ni}),
    .rst_val_i(3'b001),
    .lvl_o    (lvl),
    .rise_o   (rise),
    .fall_o   (fall)
  );

  gwr_shifter u_shift (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_lvl_i   (lvl[P_EN]),
    .en_rise_i  (rise[P_EN]),
    .en_fall_i  (fall[P_EN]),
    .sclk_rise_i(rise[P_CLK]),
    .sdat_i     (lvl[P_DAT]),
    .code_o     (code),
    .cnt_err_o  (bit_cnt_err_o)
  );

  gwr_decode u_dec (
    .code_i  (code),
    .coarse_o(coarse_step_o),
    .fine_o  (fine_step_o),
    .valid_o (code_valid_o)
  );

  assign gain_code_o = code;

  p_rst_code_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (gain_code_o == '0));
endmodule

// File: tb/gain_word_rx_bench.sv
`timescale 1ns/1ps
module gain_word_rx_bench;
  logic clk = 0, rst_n = 0;
  logic sen_n = 1, sdat = 0, sclk = 0;
  logic [6:0] code;
  logic [3:0] coarse;
  logic [2:0] fine;
  logic valid, err;
  int n_run = 0, n_fail = 0;
  logic [6:0] exp_sreg = '0, exp_code = '0;
  logic exp_err = 0;

  always #2 clk = ~clk;

  gain_word_rx u_gain_word_rx (
    .clk_i(clk), .rst_ni(rst_n), .sen_ni(sen_n), .sdat_i(sdat), .sclk_i(sclk),
    .gain_code_o(code), .coarse_step_o(coarse), .fine_step_o(fine),
    .code_valid_o(valid), .bit_cnt_err_o(err)
  );

  function automatic logic f_valid(input logic [6:0] c);
    return c <= 7'd71;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic sclk_pulse(input logic b);
    sdat = b; wait_clk(4);
    sclk = 1; wait_clk(4);
    sclk = 0;
    if (!sen_n) exp_sreg = {exp_sreg[5:0], b};
  endtask

  task automatic check_outputs(input string tag);
    chk({tag, " R4 code"}, code, exp_code);
    chk({tag, " R6 fine"}, fine, exp_code[2:0]);
    chk({tag, " R6 coarse"}, coarse, exp_code[6:3]);
    chk({tag, " R7 valid"}, valid, f_valid(exp_code));
    chk({tag, " R8 err"}, err, exp_err);
  endtask

  task automatic send(input logic [15:0] bits, input int n, input string tag);
    sen_n = 0; wait_clk(4);
    for (int i = n - 1; i >= 0; i--) begin
      sclk_pulse(bits[i]);
      if (i == n / 2) chk({tag, " R2 hold mid-load"}, code, exp_code);
    end
    wait_clk(4);
    sen_n = 1; wait_clk(8);
    exp_code = exp_sreg;
    exp_err = (n != 8);
    check_outputs(tag);
  endtask

  initial begin
    wait_clk(200000);
    n_fail++;
    $display("FAIL watchdog R1 actual=%0d expected=%0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed1));
    wait_clk(3);
    rst_n = 1; wait_clk(2);
    // R1 reset state
    chk("R1 code", code, 0);
    chk("R1 valid", valid, 1);
    chk("R1 err", err, 0);
    chk("R1 fine", fine, 0);

    // R3 R4 directed MSB-first and boundary codes
    send(16'h00C7, 8, "w71-top-set");  // R7 judged on low 7 bits
    send(16'h0047, 8, "w71");
    send(16'h0048, 8, "w72");
    send(16'h007F, 8, "w127");
    send(16'h0080, 8, "w128");
    send(16'h0001, 8, "w1");

    // R5 stray clocks with enable high, then empty load exposes the register
    sclk_pulse(1); sclk_pulse(0); sclk_pulse(1);
    chk("R5 code unchanged", code, exp_code);
    send(16'h0000, 0, "empty-R5");

    // R8 short and long words; R9 leftover bits shift onward
    send(16'h0005, 3, "short-R9");
    send(16'h03A5, 10, "long");
    send(16'h0023, 8, "clear-err");

    // random words
    for (int k = 0; k < 40; k++) begin
      logic [15:0] w;
      int n;
      w = 16'($urandom);
      n = ($urandom % 4 == 0) ? 5 + int'($urandom % 7) : 8;
      send(w, n, "rand");
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule